// File: doc/BRIEF.md
# Octal Driver Fault Latch Controller

This block sits between the serial command register of an eight-channel power driver and its gate drivers. It combines the accepted command word, four parallel PWM inputs and a global enable into the eight gate-enable outputs. It also watches per-channel over-current and open-load comparator flags, four pair-wise thermal sensors and a supply monitor. Each fault type is kept under its own rule: it may be filtered, latched or cleared, and it is reported in a 16-bit status word that the serial interface shifts out.

Over-current and open-load flags pass through one qualification counter per channel. A flag counts only after it has held for a parameterised number of clock cycles. Over-temperature acts on channel pairs. While an over-current or thermal shutdown is latched, the parallel-input bits of the status word freeze at the values seen when the fault struck. This lets software tell which command path was driving the load.

Top module: `octal_fault_ctrl`

## Requirements
- R1: Gate output k for channels 1 to 4 equals command bit k-1. For channels 5 to 8 it equals command bit k-1 OR pwm_i[k-5]. The command is captured from cmd_word_i[7:0] on frame_ok_i.
- R2: A comparator flag counts as a fault only when its condition holds at FILT_CYC consecutive clock edges. The count restarts when the condition drops.
- R3: Over-current is qualified only while the channel's gate output is on. Once qualified, it latches the channel off and sets status bit k for channel k.
- R4: An over-current latch clears only on a frame whose enable bit for that channel is 0. A frame with the bit at 1 leaves the latch set.
- R5: Open-load is qualified only while the channel is commanded off and diagnostic bit cmd_word[7+k] is set. The qualified state is sampled into status bit k on cs_fall_i and is not latched.
- R6: ot_i[p] latches thermal shutdown for channels 2p+1 and 2p+2. Both gates go off and both status bits are set, whatever the command.
- R7: A thermal latch clears only on a frame whose two enable bits for the pair are 0, and only while ot_i[p] is low.
- R8: Status bit 0 holds the OR of tw_i sampled on cs_fall_i. A warning does not turn any output off.
- R9: vs_fault_i turns all gates off at once and sets status bit 15. Bit 15 clears on a frame accepted while vs_fault_i is low. Gates return to the stored command when the fault ends.
- R10: Status bits 12..9 show pwm_i[3:0] live. While any over-current or thermal latch is set, they show pwm_i as captured on the edge the first such latch was set.
- R11: Open-load is not qualified while vs_fault_i is high or en_i is low.
- R12: en_i low forces all gates off at once and clears the command, every latch and all captured status at the next edge.
- R13: If over-current qualification and a clearing frame fall on the same edge, the latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable; low resets state and gates |
| frame_ok_i | input | 1 | One-cycle strobe: a length-checked frame was accepted |
| cmd_word_i | input | 16 | Accepted frame: [7:0] gate enables, [15:8] open-load diagnostic enables |
| cs_fall_i | input | 1 | One-cycle strobe on chip-select falling edge |
| pwm_i | input | 4 | Parallel inputs for channels 5..8 |
| oc_i | input | 8 | Per-channel over-current comparator |
| ol_i | input | 8 | Per-channel open-load comparator |
| ot_i | input | 4 | Per-pair over-temperature shutdown flag |
| tw_i | input | 4 | Per-pair thermal warning flag |
| vs_fault_i | input | 1 | Supply over- or under-voltage |
| drv_o | output | 8 | Gate enables, channel 1 at bit 0 |
| status_o | output | 16 | Status word for the serial interface |

## Verification
The sharpest coincidence is an over-current counter reaching its limit on the same edge that a frame with that channel's enable at 0 arrives. The bench holds the comparator for FILT_CYC-1 edges and then issues the clearing frame so that its strobe lands on the qualifying edge. It expects the latch to be set and the status bit to stay high until a later clearing frame. A second pairing, a thermal clear frame accepted while the sensor is still hot, is judged by the pair's status bits staying set.

// File: rtl/octal_fault_ctrl.sv
module octal_fault_ctrl #(
  parameter int FILT_CYC = 25000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic        frame_ok_i,
  input  logic [15:0] cmd_word_i,
  input  logic        cs_fall_i,
  input  logic [3:0]  pwm_i,
  input  logic [7:0]  oc_i,
  input  logic [7:0]  ol_i,
  input  logic [3:0]  ot_i,
  input  logic [3:0]  tw_i,
  input  logic        vs_fault_i,
  output logic [7:0]  drv_o,
  output logic [15:0] status_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(FILT_CYC - 1);

  logic [15:0] cmd_q;
  logic [7:0]  oc_lat, ol_cap, prev_on, tsd_ch, req, cond, hit, oc_set;
  logic [3:0]  tsd_lat, frz;
  logic        tw_cap, psm;

  assign req   = cmd_q[7:0] | {pwm_i, 4'b0000};
  assign drv_o = (en_i && !vs_fault_i) ? (req & ~oc_lat & ~tsd_ch) : 8'h00;

  wire diag_ok = en_i & ~vs_fault_i;
  assign cond  = (drv_o & oc_i) | (~req & cmd_q[15:8] & ol_i & {8{diag_ok}});

  wire any_act = (|oc_lat) | (|tsd_lat);
  wire new_evt = (|oc_set) | (|ot_i);

  genvar i, p;
  generate
    for (i = 0; i < 8; i++) begin : g_ch
      logic [CW-1:0] cnt;
      logic [CW-1:0] run;
      assign run       = (drv_o[i] == prev_on[i]) ? cnt : '0;
      assign hit[i]    = cond[i] && (run >= LIM);
      assign oc_set[i] = hit[i] & drv_o[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!en_i)      cnt <= '0;
        else if (!cond[i])   cnt <= '0;
        else if (run >= LIM) cnt <= LIM;
        else                 cnt <= run + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               oc_lat[i] <= 1'b0;
        else if (!en_i)                           oc_lat[i] <= 1'b0;
        else if (oc_set[i])                       oc_lat[i] <= 1'b1;
        else if (frame_ok_i && !cmd_word_i[i])    oc_lat[i] <= 1'b0;
      end

      a_r3_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_lat[i]) |-> $past(drv_o[i]));
      a_r4_clear_rule: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oc_lat[i]) |-> $past(!en_i || (frame_ok_i && !cmd_word_i[i])));
    end

    for (p = 0; p < 4; p++) begin : g_pair
      assign tsd_ch[2*p+1:2*p] = {2{tsd_lat[p]}};
      wire clr = frame_ok_i && !ot_i[p] && (cmd_word_i[2*p+1:2*p] == 2'b00);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tsd_lat[p] <= 1'b0;
        else if (!en_i)   tsd_lat[p] <= 1'b0;
        else if (ot_i[p]) tsd_lat[p] <= 1'b1;
        else if (clr)     tsd_lat[p] <= 1'b0;
      end

      a_r6_pair_off: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ot_i[p]) |=> (drv_o[2*p+1:2*p] == 2'b00));
      a_r7_clear_rule: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tsd_lat[p]) |-> $past(!en_i || (frame_ok_i && !ot_i[p] &&
                                     cmd_word_i[2*p+1:2*p] == 2'b00)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en_i) begin
      cmd_q   <= '0;
      ol_cap  <= '0;
      prev_on <= '0;
      frz     <= '0;
      tw_cap  <= 1'b0;
      psm     <= 1'b0;
    end else begin
      prev_on <= drv_o;
      if (frame_ok_i)            cmd_q  <= cmd_word_i;
      if (cs_fall_i)             ol_cap <= hit & ~drv_o;
      if (cs_fall_i)             tw_cap <= |tw_i;
      if (!any_act && new_evt)   frz    <= pwm_i;
      if (vs_fault_i)            psm    <= 1'b1;
      else if (frame_ok_i)       psm    <= 1'b0;
    end
  end

  assign status_o = {psm, 2'b00, any_act ? frz : pwm_i,
                     oc_lat | tsd_ch | ol_cap, tw_cap};

  a_r9_supply_set: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && vs_fault_i) |=> status_o[15]);
  a_r9_supply_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[15]) |-> $past(!en_i || (frame_ok_i && !vs_fault_i)));
  a_r12_enable_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (status_o[8:0] == 9'h000 && !status_o[15]));
endmodule

// File: tb/tb_octal_fault_ctrl.sv
`timescale 1ns/1ps
module tb_octal_fault_ctrl;
  localparam int FILT = 8;
  logic clk = 0, rst_n = 0, en_i = 0, frame_ok_i = 0, cs_fall_i = 0, vs_fault_i = 0;
  logic [15:0] cmd_word_i = '0;
  logic [3:0]  pwm_i = '0, ot_i = '0, tw_i = '0;
  logic [7:0]  oc_i = '0, ol_i = '0;
  logic [7:0]  drv_o;
  logic [15:0] status_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  octal_fault_ctrl #(.FILT_CYC(FILT)) dut (.*);

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic frame(logic [15:0] w);
    cmd_word_i = w; frame_ok_i = 1; tick(); frame_ok_i = 0;
  endtask

  task automatic csfall();
    cs_fall_i = 1; tick(); cs_fall_i = 0;
  endtask

  task automatic t_reset();
    chk("R12 reset drv", drv_o, 0);
    chk("R12 reset status", status_o, 0);
  endtask

  task automatic t_cmd_or();
    frame(16'h0003);
    chk("R1 spi only", drv_o, 8'h03);
    pwm_i = 4'b0101; #1;
    chk("R1 pwm or", drv_o, 8'h53);
    chk("R10 live mirror", status_o[12:9], 4'b0101);
    pwm_i = 0; frame(16'h0000);
  endtask

  task automatic t_overcurrent();
    frame(16'h0001);
    pwm_i = 4'b0101;
    oc_i[0] = 1; tick(FILT-1);
    chk("R2 not yet", drv_o[0], 1);
    oc_i[0] = 0; tick();
    oc_i[0] = 1; tick(FILT-1);
    chk("R2 restart", drv_o[0], 1);
    chk("R2 no status", status_o[1], 0);
    tick();
    chk("R3 latched off", drv_o[0], 0);
    chk("R3 status", status_o[1], 1);
    pwm_i = 4'b1010; #1;
    chk("R10 frozen", status_o[12:9], 4'b0101);
    oc_i[0] = 0;
    frame(16'h0001);
    chk("R4 kept by on-frame", status_o[1], 1);
    chk("R4 still off", drv_o[0], 0);
    frame(16'h0000);
    chk("R4 cleared", status_o[1], 0);
    chk("R10 live again", status_o[12:9], 4'b1010);
    pwm_i = 0;
    frame(16'h0001);
    chk("R4 back on", drv_o[0], 1);
    frame(16'h0000);
  endtask

  task automatic t_openload();
    frame(16'h0200);
    ol_i[1] = 1; tick(3);
    csfall();
    chk("R5 too early", status_o[2], 0);
    tick(3);
    csfall();
    chk("R5 reported", status_o[2], 1);
    ol_i[1] = 0; tick();
    chk("R5 held to next cs", status_o[2], 1);
    csfall();
    chk("R5 not latched", status_o[2], 0);
    frame(16'h0202);
    ol_i[1] = 1; tick(FILT+2);
    csfall();
    chk("R5 not when on", status_o[2], 0);
    frame(16'h0200);
    vs_fault_i = 1; tick(FILT+2);
    csfall();
    chk("R11 suppressed by supply", status_o[2], 0);
    vs_fault_i = 0; ol_i[1] = 0;
    frame(16'h0000);
    csfall();
  endtask

  task automatic t_thermal();
    frame(16'h0004);
    chk("R6 pre", drv_o[2], 1);
    ot_i[1] = 1; tick();
    chk("R6 pair off", drv_o[3:2], 0);
    chk("R6 both status", status_o[4:3], 2'b11);
    frame(16'h0000);
    chk("R7 hot no clear", status_o[4:3], 2'b11);
    ot_i[1] = 0;
    frame(16'h0008);
    chk("R7 pair bit set", status_o[4:3], 2'b11);
    frame(16'h0000);
    chk("R7 cleared", status_o[4:3], 2'b00);
    frame(16'h0004);
    chk("R7 back on", drv_o[2], 1);
    frame(16'h0000);
  endtask

  task automatic t_warning();
    frame(16'h0010);
    tw_i[2] = 1;
    csfall();
    chk("R8 warn bit", status_o[0], 1);
    chk("R8 stays on", drv_o[4], 1);
    tw_i[2] = 0; tick();
    chk("R8 held", status_o[0], 1);
    csfall();
    chk("R8 cleared", status_o[0], 0);
    frame(16'h0000);
  endtask

  task automatic t_supply();
    frame(16'h0081);
    vs_fault_i = 1; #1;
    chk("R9 all off", drv_o, 0);
    tick();
    chk("R9 bit15", status_o[15], 1);
    frame(16'h0081);
    chk("R9 no clear in fault", status_o[15], 1);
    vs_fault_i = 0; #1;
    chk("R9 return", drv_o, 8'h81);
    chk("R9 still latched", status_o[15], 1);
    frame(16'h0081);
    chk("R9 cleared", status_o[15], 0);
    frame(16'h0000);
  endtask

  task automatic t_same_edge();
    frame(16'h0001);
    oc_i[0] = 1; tick(FILT-1);
    frame(16'h0000);
    chk("R13 set wins", status_o[1], 1);
    oc_i[0] = 0;
    frame(16'h0000);
    chk("R13 later clear", status_o[1], 0);
  endtask

  task automatic t_enable();
    frame(16'h00FF);
    vs_fault_i = 1; tick(); vs_fault_i = 0; #1;
    chk("R12 pre", drv_o, 8'hFF);
    en_i = 0; #1;
    chk("R12 off now", drv_o, 0);
    tick(); en_i = 1; tick();
    chk("R12 cmd cleared", drv_o, 0);
    chk("R12 status cleared", status_o, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1; en_i = 1; tick();
    t_reset();
    t_cmd_or();
    t_overcurrent();
    t_openload();
    t_thermal();
    t_warning();
    t_supply();
    t_same_edge();
    t_enable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule